// File: doc/BRIEF.md
# Masked Channel Change Event Serializer

This block watches a wide vector of binary sense inputs that is presented to it one sample at a time. Whenever a sample strobe is taken, the new vector is compared with the reference vector kept from the previous sample. Each channel whose bit differs and whose enable bit is set becomes one event. An event carries the channel number and whether the bit went high or low. Events leave one at a time over a valid/ready handshake, lowest channel number first.

The reference vector is replaced by the new sample only when every event of that sample has been handed off. It takes the whole new vector, including the bits of disabled channels. A strobe that comes while a sample is still draining waits in a single holding slot. A further strobe while that slot is full is dropped and raises a sticky overrun flag. The enable mask can be rewritten at any time. A new mask applies to samples that enter processing after the write, and it does not alter events already pending.

Top module: `chev_event_gen`

## Requirements
- R1: After reset, `evt_valid`, `busy` and `overrun` are 0, every channel is enabled and the reference vector is all zeros, so a first sample produces a rising event for each of its set bits.
- R2: The change set is the reference XOR the new sample. A sample with an empty masked change set produces no event and `busy` stays 0.
- R3: Only channels whose mask bit is 1 produce events, using the mask held at the moment the sample enters processing.
- R4: Events of one sample are emitted in strictly ascending channel order, from index 0 upward.
- R5: `evt_chan` carries the 5-bit channel index. `evt_rise` is 1 when the channel's new bit is 1 (rising) and 0 when it is 0 (falling).
- R6: When a sample finishes, the whole new vector becomes the reference, including the bits of masked channels.
- R7: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid`, `evt_chan` and `evt_rise` hold their values.
- R8: `busy` rises on the clock edge that takes a sample with a non-empty change set. It falls on the edge that completes the handshake of that sample's last event, unless a held sample with changes follows at once.
- R9: A strobe that arrives while a sample is being processed is held in a one-deep slot. It is compared with the reference left by the earlier sample as soon as that sample completes.
- R10: A strobe that arrives while processing is active and the holding slot is occupied, and the slot is not being emptied on that edge, is discarded and sets `overrun`. `overrun` stays 1 until reset.
- R11: A mask write takes effect on the next clock edge. It does not cancel events already pending for a sample in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_vec | input | 32 | New sense vector |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 32 | New enable mask, bit i enables channel i |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_chan | output | 5 | Channel index of the event |
| evt_rise | output | 1 | 1 rising, 0 falling |
| busy | output | 1 | A sample is being serialized |
| overrun | output | 1 | Sticky: a strobe was lost |

## Verification
The hardest state to reach is a full holding slot hit by a third strobe. To get there, the consumer must stall while one sample is being drained and a second one is already waiting. The bench holds `evt_ready` low, issues three strobes back to back, and then drains the events. It checks that only the first two samples appear in the event stream. It then repeats the second sample and expects no event, which shows that the dropped sample never reached the reference. A second case that is hard to reach is a mask write made while events are stalled. The bench writes the mask while `evt_ready` is low and checks that the pending events still come out and that the next sample obeys the new mask.

// File: rtl/chev_pkg.sv
package chev_pkg;

    // Direction code carried on the event port.
    typedef enum logic {
        DIR_FALL = 1'b0,
        DIR_RISE = 1'b1
    } chev_dir_e;

endpackage

// File: rtl/chev_first_set.sv
// Lowest set bit finder: the index of the least significant 1 in vec_i.
module chev_first_set #(
    parameter  int unsigned W     = 32,
    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign found_o = |vec_i;

endmodule

// File: rtl/chev_mask_reg.sv
// Channel enable mask; resets with every channel enabled.
module chev_mask_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (we_i) begin
            mask_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/chev_delta.sv
// Masked difference between the reference and a candidate vector.
module chev_delta #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] ref_i,
    input  logic [W-1:0] new_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] set_o,
    output logic         any_o
);

    assign set_o = (ref_i ^ new_i) & mask_i;
    assign any_o = |set_o;

endmodule

// File: rtl/chev_event_gen.sv
module chev_event_gen
    import chev_pkg::*;
#(
    parameter  int unsigned NUM_CH = 32,
    localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [NUM_CH-1:0] smp_vec,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] mask_wdata,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [IDX_W-1:0]  evt_chan,
    output logic              evt_rise,
    output logic              busy,
    output logic              overrun
);

    typedef struct packed {
        logic              active;    // a sample is being serialized
        logic [NUM_CH-1:0] pend;      // channels still to report
        logic [NUM_CH-1:0] cur;       // sample being serialized
        logic [NUM_CH-1:0] prev;      // reference vector
        logic              hold_full; // holding slot occupied
        logic [NUM_CH-1:0] hold;      // held sample
        logic              ovr;       // sticky overrun
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] pend_left;
    logic [NUM_CH-1:0] cand;
    logic [NUM_CH-1:0] base;
    logic [NUM_CH-1:0] dset;
    logic              dany;
    logic              hs;
    logic              finishing;
    logic              slot_free;
    logic              use_hold;
    logic              use_new;
    logic              pend_any;
    logic [IDX_W-1:0]  first_idx;
    chev_dir_e         dir;

    chev_mask_reg #(.W(NUM_CH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we),
        .wdata_i (mask_wdata),
        .mask_o  (mask)
    );

    chev_first_set #(.W(NUM_CH)) u_first (
        .vec_i   (st_q.pend),
        .found_o (pend_any),
        .idx_o   (first_idx)
    );

    // Handshake and completion of the sample in progress.
    assign hs        = evt_valid & evt_ready;
    assign pend_left = hs ? (st_q.pend & (st_q.pend - NUM_CH'(1))) : st_q.pend;
    assign finishing = st_q.active & ~(|pend_left);
    assign slot_free = ~st_q.active | finishing;
    assign use_hold  = slot_free & st_q.hold_full;
    assign use_new   = slot_free & ~st_q.hold_full & smp_valid;

    // Next sample to enter processing and the reference it is compared with.
    assign cand = st_q.hold_full ? st_q.hold : smp_vec;
    assign base = st_q.active ? st_q.cur : st_q.prev;

    chev_delta #(.W(NUM_CH)) u_delta (
        .ref_i  (base),
        .new_i  (cand),
        .mask_i (mask),
        .set_o  (dset),
        .any_o  (dany)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_left;

        if (finishing) begin
            st_d.active = 1'b0;
            st_d.prev   = st_q.cur;
        end

        if (use_hold || use_new) begin
            if (dany) begin
                st_d.active = 1'b1;
                st_d.cur    = cand;
                st_d.pend   = dset;
            end else begin
                st_d.prev   = cand;
            end
        end

        if (use_hold) begin
            st_d.hold_full = 1'b0;
        end

        if (smp_valid && !use_new) begin
            if (!st_q.hold_full || use_hold) begin
                st_d.hold_full = 1'b1;
                st_d.hold      = smp_vec;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir       = st_q.cur[first_idx] ? DIR_RISE : DIR_FALL;
    assign evt_valid = st_q.active & pend_any;
    assign evt_chan  = first_idx;
    assign evt_rise  = (dir == DIR_RISE);
    assign busy      = st_q.active;
    assign overrun   = st_q.ovr;

endmodule

// File: rtl/chev_event_gen_chk.sv
module chev_event_gen_chk #(
    parameter  int unsigned NUM_CH = 32,
    localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic             evt_ready,
    input logic [IDX_W-1:0] evt_chan,
    input logic             evt_rise,
    input logic             busy,
    input logic             overrun
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!evt_valid && !busy && !overrun); // R1
        end
    end

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid && $stable(evt_chan) && $stable(evt_rise)); // R7

    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> busy); // R8

    AST_BUSY_END_ON_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(evt_valid && evt_ready)); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R10

endmodule

bind chev_event_gen chev_event_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_chan  (evt_chan),
    .evt_rise  (evt_rise),
    .busy      (busy),
    .overrun   (overrun)
);

// File: tb/chev_event_gen_test.sv
module chev_event_gen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [31:0] smp_vec;
    logic        mask_we;
    logic [31:0] mask_wdata;
    logic        evt_valid;
    logic        evt_ready;
    logic [4:0]  evt_chan;
    logic        evt_rise;
    logic        busy;
    logic        overrun;

    always #2 clk = ~clk;

    chev_event_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_vec    (smp_vec),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .evt_valid  (evt_valid),
        .evt_ready  (evt_ready),
        .evt_chan   (evt_chan),
        .evt_rise   (evt_rise),
        .busy       (busy),
        .overrun    (overrun)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          fin   = 1'b0;
    logic [31:0] prev_m;
    logic [31:0] mask_m;
    int          exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Model: queue events (chan*2+rise) in ascending order, then update reference.
    task automatic expect_sample(input logic [31:0] v);
        logic [31:0] c;
        c = (prev_m ^ v) & mask_m;
        for (int i = 0; i < 32; i++) begin
            if (c[i]) exp_q.push_back(i * 2 + int'(v[i]));
        end
        prev_m = v;
    endtask

    task automatic push(input logic [31:0] v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_vec   = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic write_mask(input logic [31:0] m);
        @(negedge clk);
        mask_we    = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
        mask_m  = m;
    endtask

    task automatic drain(input string req);
        int guard;
        int got;
        guard     = 0;
        evt_ready = 1'b1;
        while (busy || evt_valid) begin
            if (evt_valid) begin
                got = int'(evt_chan) * 2 + int'(evt_rise);
                if (exp_q.size() == 0) begin
                    check(1'b0, req, "unexpected event", got, -1);
                end else begin
                    check(got == exp_q[0], req, "event chan*2+rise", got, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            @(negedge clk);
            guard++;
            if (guard > 500) begin
                check(1'b0, req, "drain timeout", guard, 500);
                break;
            end
        end
        check(exp_q.size() == 0, req, "events missing", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic t_reset();
        rst_n      = 1'b0;
        smp_valid  = 1'b0;
        smp_vec    = '0;
        mask_we    = 1'b0;
        mask_wdata = '0;
        evt_ready  = 1'b1;
        prev_m     = '0;
        mask_m     = '1;
        repeat (3) @(negedge clk);
        check(!evt_valid && !busy && !overrun, "R1", "outputs in reset",
              {evt_valid, busy, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!evt_valid && !busy && !overrun, "R1", "outputs after reset",
              {evt_valid, busy, overrun}, 0);
    endtask

    task automatic t_first();
        expect_sample(32'h8000_0011);
        push(32'h8000_0011);
        drain("R1 R4 R5 first sample rising, ascending");
    endtask

    task automatic t_nochange();
        expect_sample(32'h8000_0011);
        push(32'h8000_0011);
        check(!busy && !evt_valid, "R2", "busy/valid on empty change",
              {busy, evt_valid}, 0);
        @(negedge clk);
        check(!busy && !evt_valid, "R2", "still idle", {busy, evt_valid}, 0);
    endtask

    task automatic t_dir();
        expect_sample(32'h0000_0013);
        push(32'h0000_0013);
        drain("R5 rise on 1, fall on 31");
    endtask

    task automatic t_mask();
        write_mask(~32'h0000_0008);
        expect_sample(32'h0000_003B);
        push(32'h0000_003B);
        drain("R3 masked channel 3 silent");
        write_mask('1);
        expect_sample(32'h0000_003B);
        push(32'h0000_003B);
        check(!busy && !evt_valid, "R6", "masked bit entered reference",
              {busy, evt_valid}, 0);
        expect_sample(32'h0000_0033);
        push(32'h0000_0033);
        drain("R6 channel 3 falls against stored reference");
    endtask

    task automatic t_stall();
        evt_ready = 1'b0;
        expect_sample(32'h0000_0437);
        push(32'h0000_0437);
        for (int k = 0; k < 5; k++) begin
            check(evt_valid == 1'b1, "R7", "valid held", evt_valid, 1);
            check(evt_chan == 5'd2, "R7", "chan held", evt_chan, 2);
            check(evt_rise == 1'b1, "R7", "dir held", evt_rise, 1);
            check(busy == 1'b1, "R8", "busy while stalled", busy, 1);
            @(negedge clk);
        end
        drain("R7 stalled events delivered");
    endtask

    task automatic t_busy_timing();
        logic [31:0] v;
        v = prev_m ^ 32'h0010_0000;
        evt_ready = 1'b1;
        expect_sample(v);
        push(v);
        check(busy == 1'b1, "R8", "busy after accept", busy, 1);
        check(evt_valid && evt_chan == 5'd20 && evt_rise,
              "R8", "single event chan", evt_chan, 20);
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy after last handshake", busy, 0);
        check(evt_valid == 1'b0, "R8", "valid after last handshake", evt_valid, 0);
        exp_q.delete();
    endtask

    task automatic t_buffer();
        logic [31:0] a;
        logic [31:0] b;
        a = prev_m ^ 32'h0000_F000;
        b = a ^ 32'h0100_0001;
        evt_ready = 1'b0;
        expect_sample(a);
        expect_sample(b);
        push(a);
        push(b);
        check(busy == 1'b1 && overrun == 1'b0, "R9", "held without overrun",
              {busy, overrun}, 2);
        drain("R9 held sample follows against new reference");
    endtask

    task automatic t_overrun();
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        a = prev_m ^ 32'h0000_0003;
        b = a ^ 32'h0000_0300;
        c = b ^ 32'h0007_0000;
        evt_ready = 1'b0;
        check(overrun == 1'b0, "R10", "overrun clear before", overrun, 0);
        expect_sample(a);
        expect_sample(b);
        push(a);
        push(b);
        check(overrun == 1'b0, "R10", "no overrun with free slot", overrun, 0);
        push(c);
        check(overrun == 1'b1, "R10", "overrun on full slot", overrun, 1);
        drain("R10 discarded sample absent");
        check(overrun == 1'b1, "R10", "overrun sticky", overrun, 1);
        expect_sample(b);
        push(b);
        check(!busy && !evt_valid, "R10", "reference is second sample",
              {busy, evt_valid}, 0);
    endtask

    task automatic t_mask_late();
        logic [31:0] v;
        v = prev_m ^ 32'h0000_0084;
        evt_ready = 1'b0;
        expect_sample(v);
        push(v);
        write_mask(~32'h0000_0080);
        drain("R11 pending events survive mask write");
        v = prev_m ^ 32'h0000_0080;
        expect_sample(v);
        push(v);
        check(!busy && !evt_valid, "R11", "new mask applied", {busy, evt_valid}, 0);
    endtask

    initial begin
        t_reset();
        t_first();
        t_nochange();
        t_dir();
        t_mask();
        t_stall();
        t_busy_timing();
        t_buffer();
        t_overrun();
        t_mask_late();
        repeat (2) @(negedge clk);
        if (!fin) begin
            fin = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule